// File: doc/BRIEF.md
# Selectable-Clock Counter Time Base

This block is a 16-bit up-counter that runs freely and serves as the common time reference for a group of compare/capture channels. Four registers, each one byte wide, sit behind a simple select / write-strobe / read-data port. They are a mode register, a control register and the two bytes of the count. The mode register chooses where count pulses come from and whether an overflow raises an interrupt. The control register holds the run bit and a sticky overflow flag.

Count pulses are formed as single-cycle ticks on the system clock. The four possible sources are:

- a slow prescaled rate;
- a fast prescaled rate;
- the overflow pulse of a neighbouring timer;
- falling edges on an asynchronous input pin.

The pin passes through a two-flop synchronizer. A rate limiter then drops edges that arrive too close together. The counter drives its value and a one-cycle count-enable strobe to the channels. A channel that sees the strobe high can rely on the count moving up by one at the next clock edge.

Top module: `shared_timebase`

## Requirements
- R1: After reset the count is 0000h, both the mode and control registers read 00h, and irq_o and cnt_en_o are low.
- R2: Select code 2 addresses the low count byte and code 3 the high count byte. A write loads that byte only, and a read returns it.
- R3: Source field 00 (mode bits 2:1) gives one increment every 12 clocks while running, or every 6 clocks when DOUBLE_SPEED=1.
- R4: Source field 01 gives one increment every 4 clocks while running, or every 2 clocks when DOUBLE_SPEED=1.
- R5: Source field 10 gives one increment for each clock in which tmr_ovf_i is high while running.
- R6: Source field 11 counts falling edges of ext_pin_i after a two-flop synchronizer. An edge is taken only if at least 8 clocks have passed since the last edge taken, or 4 clocks when DOUBLE_SPEED=1. Other edges are dropped.
- R7: Counting happens only while the run bit (control bit 6) is 1. Writing it to 0 freezes the count and holds cnt_en_o low.
- R8: An increment from FFFFh to 0000h sets the overflow flag (control bit 7). The hardware never clears it. A control write with bit 7 = 0 clears it, unless an overflow occurs in the same cycle; in that case the flag stays set.
- R9: Mode select code 0 reads {5'b0, source[1:0], irq_enable}. irq_o is high exactly while the overflow flag is set and mode bit 0 is 1.
- R10: A write to either count byte in the same cycle as a count tick takes priority. The written byte is loaded, no increment happens, and cnt_en_o is low in that cycle.
- R11: cnt_en_o is high in exactly those cycles whose closing clock edge increments cnt_o by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_sel_i | input | 2 | Register select: 0 mode, 1 control, 2 count low, 3 count high |
| reg_we_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register (combinational) |
| tmr_ovf_i | input | 1 | Overflow pulse from another timer, synchronous to clk_i |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| cnt_o | output | 16 | Current count value |
| cnt_en_o | output | 1 | Strobe: the count increments at the next clock edge |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The timing of each output is fixed relative to the stimulus:

- reg_rdata_o, irq_o and cnt_en_o are combinational from registered state, so they are due in the same cycle as the select or state that drives them.
- A register write or an increment appears on cnt_o and on read data one edge later.
- A pin edge reaches the tick logic two edges after the pin changes.

The bench drives inputs on the falling clock edge and samples outputs one nanosecond later. Its reference model advances only after the rising edge, so every comparison is made against the state the model holds for that exact cycle. The directed windows are counted from the cycle after the enabling write. Each window length is a whole number of prescaler periods, so the expected increment count does not depend on the prescaler phase.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;

  typedef enum logic [1:0] {
    SRC_SLOW = 2'b00,
    SRC_FAST = 2'b01,
    SRC_TMR  = 2'b10,
    SRC_PIN  = 2'b11
  } src_e;

  localparam logic [1:0] SEL_MODE   = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_CNT_LO = 2'd2;
  localparam logic [1:0] SEL_CNT_HI = 2'd3;

  localparam int CTRL_RUN_BIT = 6;
  localparam int CTRL_OVF_BIT = 7;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] pre_q;

  assign tick_o = run_i && (pre_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           pre_q <= '0;
    else if (!run_i)       pre_q <= '0;
    else if (pre_q == LAST) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/pin_edge_filter.sv
module pin_edge_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic tick_o
);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP_SAT = GW'(MIN_GAP);

  logic [SYNC_STAGES:0] sh_q;   // sync chain plus one history flop
  logic [GW-1:0]        gap_q;  // clocks since last accepted edge, saturating
  logic                 fall;

  assign fall   = sh_q[SYNC_STAGES] && !sh_q[SYNC_STAGES-1];
  assign tick_o = fall && (gap_q == GAP_SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      gap_q <= GAP_SAT;
    end else begin
      sh_q <= {sh_q[SYNC_STAGES-1:0], pin_i};
      if (tick_o)              gap_q <= GW'(1);
      else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
    end
  end
endmodule

// File: rtl/count_core.sv
module count_core #(
  parameter int DATA_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  inc_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic [2*DATA_W-1:0]   cnt_o,
  output logic                  wrap_o
);
  assign wrap_o = inc_i && (&cnt_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (wr_lo_i) cnt_o[DATA_W-1:0] <= wdata_i;
    else if (wr_hi_i) cnt_o[2*DATA_W-1:DATA_W] <= wdata_i;
    else if (inc_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/shared_timebase.sv
module shared_timebase
  import timebase_pkg::*;
#(
  parameter bit DOUBLE_SPEED = 1'b0,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              ext_pin_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_en_o,
  output logic              irq_o
);
  localparam int SLOW_DIV = DOUBLE_SPEED ? 6 : 12;
  localparam int FAST_DIV = DOUBLE_SPEED ? 2 : 4;
  localparam int PIN_GAP  = DOUBLE_SPEED ? 4 : 8;

  src_e src_q;
  logic irq_en_q, run_q, ovf_q;
  logic wr_mode, wr_ctrl, wr_lo, wr_hi, wr_cnt;
  logic [1:0] pre_tick;
  logic pin_tick, src_tick, cnt_en, wrap;

  assign wr_mode = reg_we_i && (reg_sel_i == SEL_MODE);
  assign wr_ctrl = reg_we_i && (reg_sel_i == SEL_CTRL);
  assign wr_lo   = reg_we_i && (reg_sel_i == SEL_CNT_LO);
  assign wr_hi   = reg_we_i && (reg_sel_i == SEL_CNT_HI);
  assign wr_cnt  = wr_lo || wr_hi;

  for (genvar g = 0; g < 2; g++) begin : g_pre
    tick_divider #(.DIV(g == 0 ? SLOW_DIV : FAST_DIV)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (run_q),
      .tick_o (pre_tick[g])
    );
  end

  pin_edge_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_GAP(PIN_GAP)) u_pin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .tick_o (pin_tick)
  );

  always_comb begin
    unique case (src_q)
      SRC_SLOW: src_tick = pre_tick[0];
      SRC_FAST: src_tick = pre_tick[1];
      SRC_TMR:  src_tick = tmr_ovf_i;
      default:  src_tick = pin_tick;
    endcase
  end

  // register write wins over a tick in the same cycle
  assign cnt_en   = run_q && src_tick && !wr_cnt;
  assign cnt_en_o = cnt_en;

  count_core #(.DATA_W(DATA_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (cnt_en),
    .wr_lo_i (wr_lo),
    .wr_hi_i (wr_hi),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt_o),
    .wrap_o  (wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= SRC_SLOW;
      irq_en_q <= 1'b0;
      run_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_mode) begin
        irq_en_q <= reg_wdata_i[0];
        src_q    <= src_e'(reg_wdata_i[2:1]);
      end
      if (wr_ctrl) run_q <= reg_wdata_i[CTRL_RUN_BIT];
      // hardware only sets; software clears with a 0; a set in the same cycle wins
      if (wrap)                                        ovf_q <= 1'b1;
      else if (wr_ctrl && !reg_wdata_i[CTRL_OVF_BIT])  ovf_q <= 1'b0;
    end
  end

  assign irq_o = ovf_q && irq_en_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_MODE: reg_rdata_o = {5'b0, src_q, irq_en_q};
      SEL_CTRL: begin
        reg_rdata_o[CTRL_OVF_BIT] = ovf_q;
        reg_rdata_o[CTRL_RUN_BIT] = run_q;
      end
      SEL_CNT_LO: reg_rdata_o = cnt_o[DATA_W-1:0];
      default:    reg_rdata_o = cnt_o[CNT_W-1:DATA_W];
    endcase
  end
endmodule

// File: rtl/shared_timebase_chk.sv
module shared_timebase_chk
  import timebase_pkg::*;
#(
  parameter int MIN_GAP = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [1:0]        reg_sel_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              cnt_en_o,
  input logic              run_q,
  input logic              ovf_q,
  input logic              pin_tick
);
  localparam int GW = $clog2(MIN_GAP + 2);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= GW'(MIN_GAP);
    else if (pin_tick)               gap_q <= GW'(1);
    else if (gap_q < GW'(MIN_GAP))   gap_q <= gap_q + 1'b1;
  end

  // R11
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> cnt_o == $past(cnt_o) + 1'b1);
  // R7
  stop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !(reg_we_i && reg_sel_i[1])) |=> $stable(cnt_o));
  // R8
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(reg_we_i && reg_sel_i == SEL_CTRL && !reg_wdata_i[CTRL_OVF_BIT])) |=> ovf_q);
  // R8
  wrap_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_o && (&cnt_o)) |=> (ovf_q && cnt_o == '0));
  // R10
  wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i[1]) |-> !cnt_en_o);
  // R2
  wr_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == SEL_CNT_LO) |=> cnt_o[DATA_W-1:0] == $past(reg_wdata_i));
  // R6
  pin_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_tick |-> gap_q >= GW'(MIN_GAP));
endmodule

bind shared_timebase shared_timebase_chk #(.MIN_GAP(PIN_GAP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .cnt_o       (cnt_o),
  .cnt_en_o    (cnt_en_o),
  .run_q       (run_q),
  .ovf_q       (ovf_q),
  .pin_tick    (pin_tick)
);

// File: tb/tb_shared_timebase.sv
module tb_shared_timebase;
  localparam bit DOUBLE_SPEED = 1'b0;
  localparam int SLOW = DOUBLE_SPEED ? 6 : 12;
  localparam int FAST = DOUBLE_SPEED ? 2 : 4;
  localparam int GAP  = DOUBLE_SPEED ? 4 : 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [1:0] reg_sel_i = '0;
  logic reg_we_i = 1'b0, tmr_ovf_i = 1'b0, ext_pin_i = 1'b1;
  logic [7:0] reg_wdata_i = '0, reg_rdata_o;
  logic [15:0] cnt_o;
  logic cnt_en_o, irq_o;

  always #4 clk = ~clk;

  shared_timebase #(.DOUBLE_SPEED(DOUBLE_SPEED)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_sel_i(reg_sel_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .tmr_ovf_i(tmr_ovf_i),
    .ext_pin_i(ext_pin_i), .cnt_o(cnt_o), .cnt_en_o(cnt_en_o), .irq_o(irq_o));

  int vectors = 0, errors = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_cnt = '0;
  logic [1:0]  m_src = '0;
  logic m_ien = 0, m_run = 0, m_ovf = 0;
  int m_pre_s = 0, m_pre_f = 0, m_gap = GAP;
  logic m_s1 = 0, m_s2 = 0, m_s3 = 0;
  // last sampled outputs
  logic [15:0] s_cnt;
  logic [7:0]  s_rdata;
  logic s_en, s_irq;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_pin_acc();
    return m_s3 && !m_s2 && (m_gap >= GAP);
  endfunction

  function automatic logic m_tick();
    case (m_src)
      2'd0: return m_run && (m_pre_s == SLOW - 1);
      2'd1: return m_run && (m_pre_f == FAST - 1);
      2'd2: return m_run && tmr_ovf_i;
      default: return m_run && m_pin_acc();
    endcase
  endfunction

  function automatic logic [7:0] m_rdata(logic [1:0] sel);
    case (sel)
      2'd0: return {5'b0, m_src, m_ien};
      2'd1: return {m_ovf, m_run, 6'b0};
      2'd2: return m_cnt[7:0];
      default: return m_cnt[15:8];
    endcase
  endfunction

  task automatic cyc(logic we, logic [1:0] sel, logic [7:0] wd, logic ovf, logic pin);
    logic e_en, acc;
    @(negedge clk);
    reg_we_i = we; reg_sel_i = sel; reg_wdata_i = wd; tmr_ovf_i = ovf; ext_pin_i = pin;
    #1;
    e_en = m_tick() && !(we && sel[1]);
    acc  = m_pin_acc();
    s_cnt = cnt_o; s_rdata = reg_rdata_o; s_en = cnt_en_o; s_irq = irq_o;
    chk("R11 cnt_en_o", cnt_en_o, e_en);
    chk("R2 R3 R4 R5 R6 cnt_o", cnt_o, m_cnt);
    chk("R9 irq_o", irq_o, m_ovf && m_ien);
    chk("R2 R9 reg_rdata_o", reg_rdata_o, m_rdata(sel));
    @(posedge clk);
    m_pre_s = (!m_run || m_pre_s == SLOW - 1) ? 0 : m_pre_s + 1;
    m_pre_f = (!m_run || m_pre_f == FAST - 1) ? 0 : m_pre_f + 1;
    m_gap = acc ? 1 : ((m_gap < GAP) ? m_gap + 1 : m_gap);
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    if (e_en && m_cnt == 16'hFFFF) m_ovf = 1;
    else if (we && sel == 2'd1 && !wd[7]) m_ovf = 0;
    if (we && sel == 2'd2) m_cnt[7:0] = wd;
    else if (we && sel == 2'd3) m_cnt[15:8] = wd;
    else if (e_en) m_cnt = m_cnt + 16'd1;
    if (we && sel == 2'd0) begin m_ien = wd[0]; m_src = wd[2:1]; end
    if (we && sel == 2'd1) m_run = wd[6];
  endtask

  task automatic idle(int n, logic [1:0] sel);
    for (int i = 0; i < n; i++) cyc(0, sel, 8'h00, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] base;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset cnt_o", cnt_o, 16'h0);
    chk("R1 reset irq_o", irq_o, 1'b0);
    chk("R1 reset cnt_en_o", cnt_en_o, 1'b0);
    rst_ni = 1'b1;
    cyc(0, 2'd0, 0, 0, 1); chk("R1 mode after reset", s_rdata, 8'h00);
    cyc(0, 2'd1, 0, 0, 1); chk("R1 ctrl after reset", s_rdata, 8'h00);

    // R3 slow source
    cyc(1, 2'd0, 8'h00, 0, 1);
    cyc(1, 2'd1, 8'h40, 0, 1);
    idle(SLOW * 5 + 1, 2'd2);
    chk("R3 five slow periods", s_cnt, 16'd5);

    // R4 fast source
    cyc(1, 2'd0, 8'h02, 0, 1);
    idle(1, 2'd0); base = s_cnt;
    idle(FAST * 4, 2'd0);
    chk("R4 four fast periods", s_cnt - base, 16'd4);
    chk("R9 mode readback", s_rdata, 8'h02);

    // R5 timer overflow source
    cyc(1, 2'd0, 8'h04, 0, 1);
    idle(1, 2'd2); base = s_cnt;
    for (int i = 0; i < 3; i++) begin cyc(0, 2'd2, 0, 1, 1); idle(2, 2'd2); end
    idle(1, 2'd2);
    chk("R5 three overflow pulses", s_cnt - base, 16'd3);

    // R6 pin source, spaced edges then crowded edges
    cyc(1, 2'd0, 8'h06, 0, 1);
    idle(GAP + 4, 2'd2); base = s_cnt;
    for (int i = 0; i < 3; i++) begin cyc(0, 2'd2, 0, 0, 0); for (int k = 0; k < GAP + 1; k++) cyc(0, 2'd2, 0, 0, 1); end
    idle(4, 2'd2);
    chk("R6 spaced edges", s_cnt - base, 16'd3);
    idle(GAP + 4, 2'd2); base = s_cnt;
    for (int i = 0; i < 16; i++) cyc(0, 2'd2, 0, 0, i[0]);
    idle(6, 2'd2);
    chk("R6 crowded edges filtered", s_cnt - base, 16'((16 + GAP - 1) / GAP));

    // R7 stop
    cyc(1, 2'd1, 8'h00, 0, 1);
    cyc(1, 2'd0, 8'h02, 0, 1);
    idle(1, 2'd2); base = s_cnt;
    idle(FAST * 6, 2'd2);
    chk("R7 stopped count holds", s_cnt, base);

    // R8 R9 overflow and interrupt
    cyc(1, 2'd2, 8'hF0, 0, 1);
    cyc(1, 2'd3, 8'hFF, 0, 1);
    cyc(1, 2'd0, 8'h03, 0, 1);
    cyc(1, 2'd1, 8'h40, 0, 1);
    idle(FAST * 16 + 2, 2'd1);
    chk("R8 flag set after wrap", s_rdata[7], 1'b1);
    chk("R9 irq with enable", s_irq, 1'b1);
    idle(FAST * 3, 2'd1);
    chk("R8 flag sticky", s_rdata[7], 1'b1);
    cyc(1, 2'd1, 8'h40, 0, 1);
    cyc(0, 2'd1, 0, 0, 1);
    chk("R8 flag cleared by write", s_rdata, 8'h40);
    chk("R9 irq drops", s_irq, 1'b0);

    // R10 write beats tick
    cyc(1, 2'd0, 8'h05, 0, 1);
    cyc(1, 2'd3, 8'h12, 0, 1);
    cyc(1, 2'd2, 8'h55, 1, 1);
    chk("R10 no strobe on write", s_en, 1'b0);
    cyc(0, 2'd2, 0, 0, 1);
    chk("R10 write wins", s_cnt, 16'h1255);

    // R8 set wins over clear in the same cycle
    cyc(1, 2'd2, 8'hFF, 0, 1);
    cyc(1, 2'd3, 8'hFF, 0, 1);
    cyc(1, 2'd1, 8'h40, 1, 1);
    cyc(0, 2'd1, 0, 0, 1);
    chk("R8 set beats clear", s_rdata[7], 1'b1);
    chk("R8 wrapped to zero", s_cnt, 16'h0000);

    // random mix
    begin
      logic pin = 1;
      for (int i = 0; i < 4000; i++) begin
        logic we; logic [1:0] sel; logic [7:0] wd;
        we  = ($urandom % 16) == 0;
        sel = 2'($urandom);
        wd  = 8'($urandom);
        if (we && sel == 2'd1) wd[6] = ($urandom % 4) != 0;
        if (($urandom % 5) == 0) pin = ~pin;
        cyc(we, sel, wd, ($urandom % 4) == 0, pin);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule